// File: doc/BRIEF.md
# Monitor Status Descriptor Generator

This block follows a stream of dword writes going into one fixed-size status buffer and keeps track of two things: how far the buffer has been filled, and where the most recent TLV began and how long it is. Several things can end the buffer's use: an error, a flush, an end-of-PPDU marker, or the buffer filling up. When one of these happens, the block builds a 128-bit, four-word completion descriptor and presents it on a valid/ready output. A drop report does not end the buffer. It produces a separate descriptor marked as empty.

The descriptor holds the following:

- the buffer address;
- a PPDU identifier, taken either from the schedule identifier or from the PHY identifier according to the initiator flag;
- a dword end offset;
- a two-bit end cause;
- the initiator bit;
- the empty flag.

The ring id and looping-count fields are written as zero, because a downstream ring stage owns them.

The control FSM has two states. `ST_COLLECT` accepts writes and events. `ST_OFFER` holds the descriptor until the consumer takes it. There are two transitions. COLLECT→OFFER is taken on any end event or drop report. OFFER→COLLECT is taken when `desc_ready` is high. While the FSM is in `ST_OFFER`, `in_ready` is low and all writes and events on the inputs are ignored.

Top module: `msd_top`

## Requirements
- R1: `desc_data[31:0]` is address bits 31:0, `desc_data[63:32]` is address bits 63:32, and `desc_data[95:64]` is the PPDU identifier. All three are sampled in the cycle of the event.
- R2: Word 3 is `desc_data[127:96]`, laid out as follows:
  - bits 11:0: end offset
  - bits 15:12: zero
  - bits 17:16: end cause (0 full, 1 flush, 2 end of PPDU, 3 truncated)
  - bit 18: initiator
  - bit 19: empty
  - bits 31:20: zero
- R3: The identifier is `sched_id` when `initiator` is 1 and `phy_ppdu_id` when `initiator` is 0.
- R4: On end of PPDU (cause 2), the offset is the last TLV's start position plus its length minus one. A write with `tlv_start` sets the start position to the write pointer before that write. If no TLV has started since the buffer began, the offset is 0.
- R5: On a flush (cause 1), the offset is the number of dwords written to the buffer, counting a write in the same cycle.
- R6: When an accepted write brings the count to `buf_size_dw`, a buffer-full descriptor (cause 0) is produced with offset `buf_size_dw`-1. A flush or error in that same cycle also reports `buf_size_dw`-1.
- R7: On an error (cause 3), the offset is computed as for a flush.
- R8: When events coincide, the order of precedence is error, then flush, then end of PPDU, then buffer full. A drop report is taken only when none of these occurs.
- R9: A drop report gives a descriptor with empty=1, cause 0 and offset 0. It does not reset the write count or the TLV record.
- R10: While `desc_valid` is high and `desc_ready` is low, `desc_data` stays stable and `in_ready` is low. Writes and events during that time have no effect.
- R11: After reset, `desc_valid` is 0 and `in_ready` is 1.
- R12: Every end descriptor (causes 0 to 3, empty=0) resets the write count and the TLV record for the next buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| buf_addr | input | 64 | Status buffer address |
| buf_size_dw | input | 13 | Buffer size in dwords (1..4096) |
| wr_valid | input | 1 | One dword written this cycle |
| tlv_start | input | 1 | This write begins a TLV |
| tlv_len_dw | input | 12 | Length of the starting TLV in dwords |
| flush_evt | input | 1 | Flush event pulse |
| eop_evt | input | 1 | End-of-PPDU event pulse |
| err_evt | input | 1 | System error truncation pulse |
| drop_evt | input | 1 | Drop report pulse |
| initiator | input | 1 | 1 = transmit initiator, 0 = responder |
| sched_id | input | 32 | Schedule identifier |
| phy_ppdu_id | input | 32 | PHY PPDU identifier |
| in_ready | output | 1 | Writes and events are accepted |
| desc_valid | output | 1 | Descriptor available |
| desc_ready | input | 1 | Consumer takes the descriptor |
| desc_data | output | 128 | Descriptor, word 0 in bits 31:0 |

## Verification
The main function is driven by several input patterns, and each one separates a different part of the design:

- A TLV-bearing run that ends in end of PPDU tells the TLV-based offset apart from a plain count of writes.
- A flush that arrives in the same cycle as a write shows whether that write is counted.
- A small buffer that fills and then receives further writes separates a correct pointer restart from a pointer that keeps counting.
- Coinciding events check the order of precedence between causes.
- A drop report followed by a flush shows that the count survives the drop.
- Writes and a flush sent while the consumer stalls show that inputs are ignored during a held descriptor.

// File: rtl/msd_pkg.sv
package msd_pkg;
    localparam int OFF_W  = 12;
    localparam int SIZE_W = OFF_W + 1;
    localparam int WORD_W = 32;
    localparam int DESC_W = 4 * WORD_W;

    typedef enum logic [1:0] {
        END_FULL  = 2'd0,
        END_FLUSH = 2'd1,
        END_PPDU  = 2'd2,
        END_TRUNC = 2'd3
    } end_cause_e;

    typedef struct packed {
        logic [3:0]       loop_cnt;
        logic [7:0]       ring;
        logic             empty;
        logic             initr;
        end_cause_e       cause;
        logic [3:0]       rsvd;
        logic [OFF_W-1:0] end_off;
    } word3_t;
endpackage

// File: rtl/msd_wptr.sv
module msd_wptr
    import msd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              tlv_start,
    input  logic [OFF_W-1:0]  tlv_len,
    input  logic [SIZE_W-1:0] buf_size,
    input  logic              clear,
    output logic              full_hit,
    output logic [OFF_W-1:0]  tlv_end,
    output logic [OFF_W-1:0]  flush_pt
);
    logic [SIZE_W-1:0] wptr_q, pos_next;
    logic [OFF_W-1:0]  toff_q, tlen_q, toff_n, tlen_n;
    logic              has_q, has_n, take_tlv;

    always_comb begin
        take_tlv = wr_en && tlv_start;
        pos_next = wptr_q + SIZE_W'(wr_en);
        full_hit = wr_en && (pos_next == buf_size);
        toff_n   = take_tlv ? wptr_q[OFF_W-1:0] : toff_q;
        tlen_n   = take_tlv ? tlv_len : tlen_q;
        has_n    = take_tlv || has_q;
        tlv_end  = has_n ? (toff_n + tlen_n - OFF_W'(1)) : '0;
        flush_pt = full_hit ? OFF_W'(buf_size - SIZE_W'(1)) : pos_next[OFF_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr_q <= '0;
            toff_q <= '0;
            tlen_q <= '0;
            has_q  <= 1'b0;
        end else if (clear) begin
            wptr_q <= '0;
            toff_q <= '0;
            tlen_q <= '0;
            has_q  <= 1'b0;
        end else if (wr_en) begin
            wptr_q <= pos_next;
            toff_q <= toff_n;
            tlen_q <= tlen_n;
            has_q  <= has_n;
        end
    end

    // R6: the pointer never rests at or past the configured size
    a_r6_ptr_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_size != '0) |-> (wptr_q < buf_size));

    // R12: an end event leaves the pointer at zero
    a_r12_ptr_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (wptr_q == '0) && !has_q);
endmodule

// File: rtl/msd_cause.sv
module msd_cause
    import msd_pkg::*;
(
    input  logic             err,
    input  logic             flush,
    input  logic             eop,
    input  logic             full,
    input  logic             drop,
    input  logic [OFF_W-1:0] flush_pt,
    input  logic [OFF_W-1:0] tlv_end,
    output logic             fire,
    output logic             end_evt,
    output end_cause_e       cause,
    output logic [OFF_W-1:0] offset,
    output logic             empty
);
    always_comb begin
        end_evt = err || flush || eop || full;
        fire    = end_evt || drop;
        empty   = 1'b0;
        cause   = END_FULL;
        offset  = '0;
        if (err) begin
            cause  = END_TRUNC;
            offset = flush_pt;
        end else if (flush) begin
            cause  = END_FLUSH;
            offset = flush_pt;
        end else if (eop) begin
            cause  = END_PPDU;
            offset = tlv_end;
        end else if (full) begin
            cause  = END_FULL;
            offset = flush_pt;
        end else if (drop) begin
            empty  = 1'b1;
        end
    end
endmodule

// File: rtl/msd_top.sv
module msd_top
    import msd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [63:0]       buf_addr,
    input  logic [SIZE_W-1:0] buf_size_dw,
    input  logic              wr_valid,
    input  logic              tlv_start,
    input  logic [OFF_W-1:0]  tlv_len_dw,
    input  logic              flush_evt,
    input  logic              eop_evt,
    input  logic              err_evt,
    input  logic              drop_evt,
    input  logic              initiator,
    input  logic [WORD_W-1:0] sched_id,
    input  logic [WORD_W-1:0] phy_ppdu_id,
    output logic              in_ready,
    output logic              desc_valid,
    input  logic              desc_ready,
    output logic [DESC_W-1:0] desc_data
);
    typedef enum logic [0:0] {ST_COLLECT = 1'b0, ST_OFFER = 1'b1} state_e;

    state_e           state_q, state_n;
    logic             open_g, wr_en, full_hit, fire, end_evt, empty;
    logic [OFF_W-1:0] tlv_end, flush_pt, offset;
    end_cause_e       cause;
    word3_t           w3;

    assign open_g = (state_q == ST_COLLECT);
    assign wr_en  = wr_valid && open_g;

    msd_wptr u_wptr (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .tlv_start(tlv_start),
        .tlv_len(tlv_len_dw), .buf_size(buf_size_dw), .clear(end_evt),
        .full_hit(full_hit), .tlv_end(tlv_end), .flush_pt(flush_pt)
    );

    msd_cause u_cause (
        .err(err_evt && open_g), .flush(flush_evt && open_g),
        .eop(eop_evt && open_g), .full(full_hit), .drop(drop_evt && open_g),
        .flush_pt(flush_pt), .tlv_end(tlv_end), .fire(fire),
        .end_evt(end_evt), .cause(cause), .offset(offset), .empty(empty)
    );

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_COLLECT: if (fire)       state_n = ST_OFFER;
            ST_OFFER:   if (desc_ready) state_n = ST_COLLECT;
            default:                    state_n = ST_COLLECT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_COLLECT;
        else        state_q <= state_n;
    end

    always_comb begin
        w3          = '0;
        w3.end_off  = offset;
        w3.cause    = cause;
        w3.initr    = initiator;
        w3.empty    = empty;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            desc_data <= '0;
        end else if (open_g && fire) begin
            desc_data <= {w3, (initiator ? sched_id : phy_ppdu_id), buf_addr};
        end
    end

    assign desc_valid = (state_q == ST_OFFER);
    assign in_ready   = (state_q == ST_COLLECT);

    // R10: a held descriptor does not change
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        desc_valid && !desc_ready |=> desc_valid && $stable(desc_data));
    // R10: valid drops only after an accept
    a_r10_release: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(desc_valid) |-> $past(desc_ready));
    // R2: reserved, ring and loop fields are zero
    a_r2_zero_fields: assert property (@(posedge clk) disable iff (!rst_n)
        desc_valid |-> (desc_data[127:116] == '0) && (desc_data[111:108] == '0));
    // R9: an empty descriptor carries cause 0 and offset 0
    a_r9_empty_desc: assert property (@(posedge clk) disable iff (!rst_n)
        desc_valid && desc_data[115] |-> (desc_data[113:96] == '0));
    // R8: an error always wins
    a_r8_err_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(desc_valid) && $past(err_evt) |-> (desc_data[113:112] == 2'd3));
endmodule

// File: tb/test_msd_top.sv
module test_msd_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [63:0]  buf_addr = '0;
    logic [12:0]  buf_size_dw = 13'd64;
    logic         wr_valid = 0, tlv_start = 0, flush_evt = 0, eop_evt = 0;
    logic         err_evt = 0, drop_evt = 0, initiator = 0, hold_ready = 0;
    logic [11:0]  tlv_len_dw = '0;
    logic [31:0]  sched_id = '0, phy_ppdu_id = '0;
    logic         in_ready, desc_valid, desc_ready;
    logic [127:0] desc_data;

    int checks = 0, failures = 0, seq = 0;
    int mw = 0, mo = 0, ml = 0;
    bit mh = 0;
    logic [127:0] exp_q[$];
    string        tag_q[$];
    bit           was_held = 0;
    logic [127:0] held;

    always #5 clk = ~clk;
    assign desc_ready = !hold_ready;

    msd_top i_msd_top (
        .clk(clk), .rst_n(rst_n), .buf_addr(buf_addr), .buf_size_dw(buf_size_dw),
        .wr_valid(wr_valid), .tlv_start(tlv_start), .tlv_len_dw(tlv_len_dw),
        .flush_evt(flush_evt), .eop_evt(eop_evt), .err_evt(err_evt),
        .drop_evt(drop_evt), .initiator(initiator), .sched_id(sched_id),
        .phy_ppdu_id(phy_ppdu_id), .in_ready(in_ready), .desc_valid(desc_valid),
        .desc_ready(desc_ready), .desc_data(desc_data)
    );

    task automatic check(string req, logic [127:0] got, logic [127:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    // drive one cycle; when modelled, wait for acceptance and predict the descriptor
    task automatic drive(bit wr, bit ts, int len, bit fl, bit eo, bit er, bit dr,
                         bit modelled, string tag);
        int pn, offn, lenn, tend, fpt, off, rsn;
        bit hasn, full, fire, endv, emp;
        logic [31:0] w3;
        if (modelled) while (!in_ready) begin @(posedge clk); #1; end
        seq++;
        buf_addr    = {32'hA5A50000 + 32'(seq), 32'h10000000 + 32'(seq)};
        sched_id    = 32'h5C000000 + 32'(seq);
        phy_ppdu_id = 32'hB0000000 + 32'(seq);
        wr_valid = wr; tlv_start = ts; tlv_len_dw = 12'(len);
        flush_evt = fl; eop_evt = eo; err_evt = er; drop_evt = dr;
        if (modelled) begin
            pn   = mw + int'(wr);
            full = wr && (pn == int'(buf_size_dw));
            offn = (wr && ts) ? mw : mo;
            lenn = (wr && ts) ? len : ml;
            hasn = (wr && ts) || mh;
            tend = hasn ? ((offn + lenn - 1) & 12'hFFF) : 0;
            fpt  = full ? int'(buf_size_dw) - 1 : pn;
            endv = er || fl || eo || full;
            fire = endv || dr;
            emp = 0; off = 0; rsn = 0;
            if (er)      begin rsn = 3; off = fpt;  end
            else if (fl) begin rsn = 1; off = fpt;  end
            else if (eo) begin rsn = 2; off = tend; end
            else if (full) begin rsn = 0; off = fpt; end
            else if (dr) emp = 1;
            if (fire) begin
                w3 = {12'h0, emp, initiator, 2'(rsn), 4'h0, 12'(off)};
                exp_q.push_back({w3, initiator ? sched_id : phy_ppdu_id, buf_addr});
                tag_q.push_back(tag);
            end
            if (endv) begin mw = 0; mo = 0; ml = 0; mh = 0; end
            else begin mw = pn; mo = offn; ml = lenn; mh = hasn; end
        end
        @(posedge clk); #1;
        wr_valid = 0; tlv_start = 0; flush_evt = 0; eop_evt = 0; err_evt = 0; drop_evt = 0;
    endtask

    task automatic writes(int n);
        for (int i = 0; i < n; i++) drive(1, 0, 0, 0, 0, 0, 0, 1, "R12");
    endtask

    task automatic drain();
        int guard = 0;
        while (exp_q.size() != 0 && guard < 200) begin @(posedge clk); #1; guard++; end
        while (!in_ready) begin @(posedge clk); #1; end
    endtask

    // monitor: compare accepted descriptors, check holds
    always @(negedge clk) begin
        if (rst_n && desc_valid) begin
            if (was_held) check("R10 held descriptor stable", desc_data, held);
            if (desc_ready) begin
                if (exp_q.size() == 0) begin
                    checks++; failures++;
                    $display("FAIL R10 unexpected descriptor got=%h exp=none", desc_data);
                end else begin
                    string t = tag_q.pop_front();
                    check(t, desc_data, exp_q.pop_front());
                end
                was_held = 0;
            end else begin
                was_held = 1; held = desc_data;
            end
        end else was_held = 0;
    end

    initial begin
        #(200000 * 10);
        checks++; failures++;
        $display("FAIL watchdog got=timeout exp=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #12;
        check("R11 reset valid", {127'h0, desc_valid}, 128'h0);
        check("R11 reset in_ready", {127'h0, in_ready}, 128'h1);
        rst_n = 1;
        @(posedge clk); #1;

        // R4: TLV at position 3, length 5 -> offset 7; R1/R3 id from PHY
        writes(3);
        drive(1, 1, 5, 0, 0, 0, 0, 1, "R4 tlv end");
        writes(4);
        drive(0, 0, 0, 0, 1, 0, 0, 1, "R4 eop offset, R1 R3 phy id");
        drain();
        // R5/R3: initiator 1, flush with same-cycle write
        initiator = 1;
        writes(6);
        drive(1, 0, 0, 1, 0, 0, 0, 1, "R5 flush point, R3 sched id");
        drain();
        // R4: end of PPDU with no TLV -> offset 0
        writes(2);
        drive(0, 0, 0, 0, 1, 0, 0, 1, "R4 no tlv");
        drain();
        // R6: small buffer fills, then R12 pointer restarts
        initiator = 0;
        buf_size_dw = 13'd8;
        writes(7);
        drive(1, 0, 0, 0, 0, 0, 0, 1, "R6 buffer full");
        drain();
        writes(2);
        drive(0, 0, 0, 1, 0, 0, 0, 1, "R12 restart after full");
        drain();
        // R7: error truncation
        writes(3);
        drive(1, 0, 0, 0, 0, 1, 0, 1, "R7 truncated");
        drain();
        // R8: precedence
        writes(1);
        drive(1, 0, 0, 1, 1, 1, 0, 1, "R8 error beats flush and eop");
        drain();
        writes(2);
        drive(0, 0, 0, 1, 1, 0, 1, 1, "R8 flush beats eop and drop");
        drain();
        drive(1, 1, 4, 0, 0, 0, 0, 1, "R8 tlv");
        writes(6);
        drive(1, 0, 0, 0, 1, 0, 0, 1, "R8 eop beats full");
        drain();
        writes(7);
        drive(1, 0, 0, 1, 0, 0, 0, 1, "R6 flush with full reports size-1");
        drain();
        // R9 and R10: drop keeps count; stall ignores inputs
        buf_size_dw = 13'd64;
        writes(2);
        hold_ready = 1;
        drive(0, 0, 0, 0, 0, 0, 1, 1, "R9 drop descriptor");
        check("R10 in_ready low while held", {127'h0, in_ready}, 128'h0);
        drive(1, 0, 0, 0, 0, 0, 0, 0, "R10 ignored");
        drive(1, 0, 0, 1, 0, 0, 0, 0, "R10 ignored");
        drive(0, 0, 0, 0, 1, 1, 0, 0, "R10 ignored");
        hold_ready = 0;
        drain();
        drive(0, 0, 0, 1, 0, 0, 0, 1, "R9 R10 count kept across drop and stall");
        drain();
        // R2: stall on a full-field descriptor
        initiator = 1;
        hold_ready = 1;
        writes(5);
        drive(1, 1, 9, 0, 0, 0, 0, 1, "R2 tlv");
        drive(0, 0, 0, 0, 1, 0, 0, 1, "R2 word3 layout");
        repeat (3) begin @(posedge clk); #1; end
        hold_ready = 0;
        drain();
        repeat (3) begin @(posedge clk); #1; end
        check("R1 all descriptors delivered", 128'(exp_q.size()), 128'h0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule